// File: doc/BRIEF.md
# Wide-Word Dual-Side Memory Core

This block is a storage array with two independent views. On the user side it looks like one memory of `W`-bit words, `DEPTH` entries deep. The port has an address, write data, a one-cycle write strobe and registered read data. On the host side the same bits appear as a row of 16-bit register memories, one for each 16-bit slice of the user word, laid end to end in a 16-bit bus address space. The row starts at `BASE`. Bus address `BASE + a + i*DEPTH` reaches slice `i` of user word `a`. Slice 0 carries the least significant bits. When `W` is not a multiple of 16, the last slice is narrow.

A `MODE` parameter chooses the traffic allowed:
- In bidirectional mode, both sides read and write.
- In user-to-host mode, the user side only writes and the bus side only reads.
- In host-to-user mode, the bus side only writes and the user side only reads.

Bus requests are single-cycle strobes carrying address, write data and a write flag. A read answers with a one-cycle response flag and data at a fixed latency.

Top module: `wdm_core`

## Requirements
- R1: After reset every location reads as zero from both sides: `usr_rdata` is 0 and every in-window bus read returns 0.
- R2: A user write takes effect in the cycle `usr_we` is high. The user read data for an address shows on `usr_rdata` after the second rising edge following the edge at which the address is sampled. After only one edge, the previous word is still shown.
- R3: Bus address `BASE + a + i*DEPTH` maps to bits `[16*i +: 16]` of user word `a` (slice 0 holds bits 15:0). The window covers `BASE` to `BASE + ceil(W/16)*DEPTH - 1`.
- R4: A bus read of a slice returns the last value written to that slice, whether the write came from the user side or the bus side.
- R5: A user read returns the concatenation of all slices at that address, including slices last written from the bus.
- R6: The top slice is `W mod 16` bits wide when that is non-zero. Bus writes to it keep only those low bits. Bus reads of it return zero in bits above them.
- R7: An accepted bus read (`bus_valid`=1, `bus_write`=0, address in window) raises `bus_rvalid` for one cycle, two rising edges after the request edge, with the data on `bus_rdata`. Bus writes produce no response.
- R8: A bus request outside the window is ignored. It writes nothing, raises no `bus_rvalid`, and leaves `bus_rdata` unchanged. In all cases `bus_rdata` changes only together with `bus_rvalid`.
- R9: When a user write and a bus write hit the same slice location in the same cycle, the user data is stored.
- R10: In user-to-host mode, bus writes are ignored and `usr_rdata` stays zero. User writes remain visible to bus reads.
- R11: In host-to-user mode, user writes are ignored and bus reads get no response. Bus writes remain visible on the user side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_addr | input | $clog2(DEPTH) | User word address |
| usr_wdata | input | W | User write data |
| usr_we | input | 1 | User write strobe, one cycle per write |
| usr_rdata | output | W | User read data, two cycles after address |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, held between responses |
| bus_rvalid | output | 1 | One-cycle read response flag |

## Verification
The hardest case to reach from the ports is a user write and a bus write landing on the same slice location in one cycle. A sequential driver never produces that overlap. The bench therefore drives both strobes on one clock edge in a directed step. It then reads the location back from both sides and also checks an instance whose mode blocks user writes, where the bus value must win. Window edges (`BASE-1`, the last slice entry, one past the end) and the narrow top slice are also forced by directed writes. These are mixed with seeded random traffic, which is aimed at a small set of addresses so that reads often hit data written earlier by the other side.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

  typedef enum logic [1:0] {
    XM_BIDIR        = 2'd0,
    XM_USER_TO_HOST = 2'd1,
    XM_HOST_TO_USER = 2'd2
  } xfer_mode_e;

  localparam int BUS_DW = 16;

  // number of 16-bit bus slices that make up one user word
  function automatic int slice_count(int w);
    return (w + BUS_DW - 1) / BUS_DW;
  endfunction

  // width of slice i; only the last one may be narrow
  function automatic int slice_w(int w, int i);
    int n;
    n = slice_count(w);
    return (i < n - 1) ? BUS_DW : w - BUS_DW * (n - 1);
  endfunction

endpackage

// File: rtl/wdm_bus_decode.sv
module wdm_bus_decode #(
  parameter int NS     = 2,
  parameter int DEPTH  = 512,
  parameter int BASE   = 0,
  parameter int BUS_AW = 16,
  parameter int UAW    = 9,
  parameter int SIW    = 1
) (
  input  logic [BUS_AW-1:0] addr,
  output logic              hit,
  output logic [SIW-1:0]    sel,
  output logic [UAW-1:0]    lcl
);
  localparam int SPAN = NS * DEPTH;

  logic [31:0] off;
  logic        above;

  assign above = 32'(addr) >= 32'(BASE);
  assign off   = 32'(addr) - 32'(BASE);
  assign hit   = above && (off < 32'(SPAN));

  // stride comparators instead of a divider
  always_comb begin
    sel = '0;
    lcl = '0;
    for (int i = 0; i < NS; i++) begin
      if (off >= 32'(i * DEPTH) && off < 32'((i + 1) * DEPTH)) begin
        sel = SIW'(i);
        lcl = UAW'(off - 32'(i * DEPTH));
      end
    end
  end
endmodule

// File: rtl/wdm_slice.sv
module wdm_slice #(
  parameter int SW    = 16,
  parameter int DEPTH = 512,
  parameter int UAW   = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           u_we,
  input  logic [UAW-1:0] u_addr,
  input  logic [SW-1:0]  u_wdata,
  output logic [SW-1:0]  u_rdata,
  input  logic           b_we,
  input  logic [UAW-1:0] b_addr,
  input  logic [SW-1:0]  b_wdata,
  output logic [SW-1:0]  b_rdata
);
  logic [SW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] filled;
  logic             b_commit;

  // the user side wins a same-location collision
  assign b_commit = b_we && !(u_we && (u_addr == b_addr));

  always_ff @(posedge clk) begin
    if (u_we)     mem[u_addr] <= u_wdata;
    if (b_commit) mem[b_addr] <= b_wdata;
  end

  // per-entry written flags give a zero image right after reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filled <= '0;
    end else begin
      if (u_we) filled[u_addr] <= 1'b1;
      if (b_we) filled[b_addr] <= 1'b1;
    end
  end

  assign u_rdata = filled[u_addr] ? mem[u_addr] : '0;
  assign b_rdata = filled[b_addr] ? mem[b_addr] : '0;
endmodule

// File: rtl/wdm_core.sv
module wdm_core #(
  parameter int                  W      = 23,
  parameter int                  DEPTH  = 512,
  parameter int                  BASE   = 0,
  parameter wdm_pkg::xfer_mode_e MODE   = wdm_pkg::XM_BIDIR,
  localparam int                 UAW    = $clog2(DEPTH),
  localparam int                 BUS_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UAW-1:0]    usr_addr,
  input  logic [W-1:0]      usr_wdata,
  input  logic              usr_we,
  output logic [W-1:0]      usr_rdata,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid
);
  import wdm_pkg::*;

  localparam int NS  = slice_count(W);
  localparam int SIW = (NS > 1) ? $clog2(NS) : 1;
  localparam bit USER_WR_OK = (MODE != XM_HOST_TO_USER);
  localparam bit USER_RD_OK = (MODE != XM_USER_TO_HOST);
  localparam bit BUS_WR_OK  = (MODE != XM_USER_TO_HOST);
  localparam bit BUS_RD_OK  = (MODE != XM_HOST_TO_USER);

  // named internal events
  logic           bus_hit;
  logic [SIW-1:0] bus_sel;
  logic [UAW-1:0] bus_lcl;
  logic           bus_wr_fire;
  logic           bus_rd_fire;
  logic           usr_wr_fire;
  logic           rsp_top;

  logic [W-1:0]   usr_cat;
  logic [W-1:0]   usr_s1;
  logic [15:0]    bus_slice_rd [NS];
  logic           s1_valid;
  logic [15:0]    s1_data;
  logic           s1_top;

  wdm_bus_decode #(
    .NS(NS), .DEPTH(DEPTH), .BASE(BASE), .BUS_AW(BUS_AW), .UAW(UAW), .SIW(SIW)
  ) u_dec (
    .addr(bus_addr), .hit(bus_hit), .sel(bus_sel), .lcl(bus_lcl)
  );

  assign bus_wr_fire = bus_valid &&  bus_write && bus_hit && BUS_WR_OK;
  assign bus_rd_fire = bus_valid && !bus_write && bus_hit && BUS_RD_OK;
  assign usr_wr_fire = usr_we && USER_WR_OK;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    localparam int SW = slice_w(W, i);
    logic [SW-1:0] b_rd;

    wdm_slice #(.SW(SW), .DEPTH(DEPTH), .UAW(UAW)) u_slc (
      .clk(clk), .rst_n(rst_n),
      .u_we(usr_wr_fire), .u_addr(usr_addr),
      .u_wdata(usr_wdata[16*i +: SW]), .u_rdata(usr_cat[16*i +: SW]),
      .b_we(bus_wr_fire && (bus_sel == SIW'(i))), .b_addr(bus_lcl),
      .b_wdata(bus_wdata[SW-1:0]), .b_rdata(b_rd)
    );

    assign bus_slice_rd[i] = 16'(b_rd);
  end

  // user read: sample stage, then output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usr_s1    <= '0;
      usr_rdata <= '0;
    end else begin
      usr_s1    <= usr_cat;
      usr_rdata <= USER_RD_OK ? usr_s1 : '0;
    end
  end

  // bus read: same two-stage shape, data held between responses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_data    <= '0;
      s1_top     <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      rsp_top    <= 1'b0;
    end else begin
      s1_valid   <= bus_rd_fire;
      bus_rvalid <= s1_valid;
      if (bus_rd_fire) begin
        s1_data <= bus_slice_rd[bus_sel];
        s1_top  <= (bus_sel == SIW'(NS - 1));
      end
      if (s1_valid) begin
        bus_rdata <= s1_data;
        rsp_top   <= s1_top;
      end
    end
  end
endmodule

// File: rtl/wdm_core_chk.sv
module wdm_core_chk #(
  parameter int                  W    = 23,
  parameter wdm_pkg::xfer_mode_e MODE = wdm_pkg::XM_BIDIR
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_valid,
  input logic         bus_write,
  input logic         bus_hit,
  input logic         bus_rvalid,
  input logic [15:0]  bus_rdata,
  input logic         rsp_top,
  input logic [W-1:0] usr_rdata
);
  import wdm_pkg::*;

  localparam int TOP_W  = slice_w(W, slice_count(W) - 1);
  localparam bit RD_OK  = (MODE != XM_HOST_TO_USER);
  localparam bit U2H    = (MODE == XM_USER_TO_HOST);
  localparam bit H2U    = (MODE == XM_HOST_TO_USER);

  // R1: outputs are clear on the first cycle out of reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (usr_rdata == '0 && !bus_rvalid && bus_rdata == '0));

  // R7: an accepted read is answered two edges later
  a_r7_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (RD_OK && bus_valid && !bus_write && bus_hit) |-> ##2 bus_rvalid);

  // R7 / R8: no response without an in-window read two cycles before
  a_r8_no_orphan_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write && bus_hit, 2));

  // R8: read data only moves with a response
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> $stable(bus_rdata));

  // R6: upper bits of a top-slice response are zero
  a_r6_top_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && rsp_top) |-> ((32'(bus_rdata) >> TOP_W) == 32'd0));

  // R10: user-to-host mode never shows user data
  a_r10_no_user_rd: assert property (@(posedge clk) disable iff (!rst_n)
    U2H |-> (usr_rdata == '0));

  // R11: host-to-user mode never answers bus reads
  a_r11_no_bus_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    H2U |-> !bus_rvalid);
endmodule

bind wdm_core wdm_core_chk #(.W(W), .MODE(MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_hit(bus_hit), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
  .rsp_top(rsp_top), .usr_rdata(usr_rdata)
);

// File: tb/sim_wdm_core.sv
module sim_wdm_core;
  import wdm_pkg::*;

  localparam int W     = 23;
  localparam int DEPTH = 512;
  localparam int BASE  = 16'h0200;
  localparam int NI    = 3;   // 0 bidir, 1 user->host, 2 host->user

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  usr_addr = '0;
  logic [22:0] usr_wdata = '0;
  logic        usr_we = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;

  logic [22:0] urd [NI];
  logic [15:0] brd [NI];
  logic        bvl [NI];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] mdl [NI][2][DEPTH];

  always #5 clk = ~clk;

  wdm_core #(.W(W), .DEPTH(DEPTH), .BASE(BASE), .MODE(XM_BIDIR)) u0 (
    .clk(clk), .rst_n(rst_n), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_we(usr_we), .usr_rdata(urd[0]), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(brd[0]), .bus_rvalid(bvl[0]));

  wdm_core #(.W(W), .DEPTH(DEPTH), .BASE(BASE), .MODE(XM_USER_TO_HOST)) u1 (
    .clk(clk), .rst_n(rst_n), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_we(usr_we), .usr_rdata(urd[1]), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(brd[1]), .bus_rvalid(bvl[1]));

  wdm_core #(.W(W), .DEPTH(DEPTH), .BASE(BASE), .MODE(XM_HOST_TO_USER)) u2 (
    .clk(clk), .rst_n(rst_n), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_we(usr_we), .usr_rdata(urd[2]), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(brd[2]), .bus_rvalid(bvl[2]));

  // ---- bench-side restatement of the mapping ----
  function automatic bit in_win(int a);
    return a >= BASE && a < BASE + 2 * DEPTH;
  endfunction
  function automatic int slc_of(int a);
    return (a - BASE) / DEPTH;
  endfunction
  function automatic int ent_of(int a);
    return (a - BASE) % DEPTH;
  endfunction
  function automatic logic [15:0] keep(int s);
    return (s == 0) ? 16'hFFFF : 16'h007F;
  endfunction
  function automatic bit uw_ok(int i); return i != 2; endfunction
  function automatic bit ur_ok(int i); return i != 1; endfunction
  function automatic bit bw_ok(int i); return i != 1; endfunction
  function automatic bit br_ok(int i); return i != 2; endfunction
  function automatic logic [22:0] word_of(int i, int a);
    return {mdl[i][1][a][6:0], mdl[i][0][a]};
  endfunction

  task automatic chk(bit ok, string req, int inst, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s u%0d actual=%h expected=%h t=%0t", req, inst, act, exp, $time);
    end
  endtask

  task automatic model_uw(int a, logic [22:0] d);
    for (int i = 0; i < NI; i++)
      if (uw_ok(i)) begin
        mdl[i][0][a] = d[15:0];
        mdl[i][1][a] = {9'd0, d[22:16]};
      end
  endtask

  task automatic model_bw(int a, logic [15:0] d);
    if (in_win(a))
      for (int i = 0; i < NI; i++)
        if (bw_ok(i)) mdl[i][slc_of(a)][ent_of(a)] = d & keep(slc_of(a));
  endtask

  task automatic user_write(int a, logic [22:0] d);
    @(negedge clk);
    usr_addr = 9'(a); usr_wdata = d; usr_we = 1'b1;
    @(negedge clk);
    usr_we = 1'b0; usr_wdata = '0;
    model_uw(a, d);
  endtask

  task automatic bus_wr(int a, logic [15:0] d);
    @(negedge clk);
    bus_addr = 16'(a); bus_wdata = d; bus_write = 1'b1; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    model_bw(a, d);
  endtask

  task automatic bus_rd(int a, string req);
    logic [15:0] prev [NI];
    @(negedge clk);
    for (int i = 0; i < NI; i++) prev[i] = brd[i];
    bus_addr = 16'(a); bus_write = 1'b0; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
    for (int i = 0; i < NI; i++)
      chk(bvl[i] == 1'b0, {req, "/R7 early"}, i, 32'(bvl[i]), 32'd0);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      if (in_win(a) && br_ok(i)) begin
        chk(bvl[i] == 1'b1, {req, "/R7 rvalid"}, i, 32'(bvl[i]), 32'd1);
        chk(brd[i] == mdl[i][slc_of(a)][ent_of(a)], req, i,
            32'(brd[i]), 32'(mdl[i][slc_of(a)][ent_of(a)]));
      end else begin
        chk(bvl[i] == 1'b0, {req, "/R8 no rsp"}, i, 32'(bvl[i]), 32'd0);
        chk(brd[i] == prev[i], {req, "/R8 hold"}, i, 32'(brd[i]), 32'(prev[i]));
      end
    end
    @(negedge clk);
    for (int i = 0; i < NI; i++)
      chk(bvl[i] == 1'b0, {req, "/R7 pulse"}, i, 32'(bvl[i]), 32'd0);
  endtask

  task automatic user_rd(int a, string req);
    @(negedge clk);
    usr_addr = 9'(a);
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      logic [22:0] e;
      e = ur_ok(i) ? word_of(i, a) : 23'd0;
      chk(urd[i] == e, req, i, 32'(urd[i]), 32'(e));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NI; i++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < DEPTH; a++) mdl[i][s][a] = '0;
    void'($urandom(32'd20240306));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: zero image from both sides
    for (int i = 0; i < NI; i++) chk(urd[i] == '0, "R1 usr reset", i, 32'(urd[i]), 32'd0);
    user_rd(0, "R1 user zero");
    user_rd(DEPTH - 1, "R1 user zero top");
    bus_rd(BASE, "R1 bus zero");
    bus_rd(BASE + 2 * DEPTH - 1, "R1 bus zero last");

    // R3/R4: user word spread over slices, slice 0 low bits
    user_write(5, 23'h5ABCD);
    bus_rd(BASE + 5, "R3 slice0 of user word");
    bus_rd(BASE + DEPTH + 5, "R3 slice1 of user word");
    bus_rd(BASE + 4, "R3 neighbour untouched");

    // R5/R6: bus writes, narrow top slice masked
    bus_wr(BASE + 9, 16'h1234);
    bus_wr(BASE + DEPTH + 9, 16'hFFFF);
    bus_rd(BASE + DEPTH + 9, "R6 top slice masked");
    user_rd(9, "R5 user sees bus slices");
    bus_wr(BASE + 2 * DEPTH - 1, 16'hFF81);
    user_rd(DEPTH - 1, "R3 window edge");

    // R2: latency, previous word shown after one edge
    user_rd(5, "R2 first word");
    @(negedge clk);
    usr_addr = 9'd9;
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      logic [22:0] e;
      e = ur_ok(i) ? word_of(i, 5) : 23'd0;
      chk(urd[i] == e, "R2 one edge old word", i, 32'(urd[i]), 32'(e));
    end
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      logic [22:0] e;
      e = ur_ok(i) ? word_of(i, 9) : 23'd0;
      chk(urd[i] == e, "R2 two edges new word", i, 32'(urd[i]), 32'(e));
    end

    // R8: out-of-window requests ignored
    bus_wr(BASE - 1, 16'hDEAD);
    bus_wr(BASE + 2 * DEPTH, 16'hBEEF);
    bus_rd(BASE - 1, "R8 below window");
    bus_rd(BASE + 2 * DEPTH, "R8 above window");
    user_rd(0, "R8 no stray write low");
    user_rd(DEPTH - 1, "R8 no stray write high");

    // R9: same-cycle collision, user side wins
    @(negedge clk);
    usr_addr = 9'd7; usr_wdata = 23'h012345; usr_we = 1'b1;
    bus_addr = 16'(BASE + 7); bus_wdata = 16'hAAAA; bus_write = 1'b1; bus_valid = 1'b1;
    @(negedge clk);
    usr_we = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    for (int i = 0; i < NI; i++) begin
      if (uw_ok(i)) begin
        mdl[i][0][7] = 16'h2345; mdl[i][1][7] = 16'h0001;
      end else if (bw_ok(i)) begin
        mdl[i][0][7] = 16'hAAAA;
      end
    end
    bus_rd(BASE + 7, "R9 collision bus view");
    user_rd(7, "R9 collision user view");

    // R10/R11 plus R4/R5 mixed: seeded random traffic
    for (int n = 0; n < 500; n++) begin
      int op, a, s;
      op = int'($urandom % 4);
      a  = int'($urandom % 12) + ((($urandom % 2) == 0) ? 0 : DEPTH - 12);
      s  = int'($urandom % 2);
      case (op)
        0: user_write(a, 23'($urandom));
        1: begin
          if (($urandom % 8) == 0) bus_wr(BASE - 1 - int'($urandom % 3), 16'($urandom));
          else bus_wr(BASE + s * DEPTH + a, 16'($urandom));
        end
        2: user_rd(a, "R5/R10/R11 random user read");
        default: bus_rd(BASE + s * DEPTH + a, "R4/R10/R11 random bus read");
      endcase
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule